// File: doc/BRIEF.md
# Four-Bank Open-Row Tracker

This block follows the row state of a four-bank DRAM device from the decoded command stream a memory controller issues. For every bank it records whether a row is latched in the sense amplifier and, if so, which of the 4096 rows it is. A controller or a protocol monitor uses these outputs to choose between a column access, an activate or a precharge, and uses the error outputs to flag command sequences the device would not accept.

A bank can be closed in three ways. The first is a precharge sent on the row command path. The second is the auto-precharge variant of a read, write or no-op column command. The third is an extended precharge sent on the column path. The extended precharge is accepted only when the column command before it was a read or a write with the byte mask off. A single device-wide arm flag records this condition. Every accepted column command updates the flag. An extended precharge reads the flag but leaves it unchanged.

Legality is judged against the state registered at the start of each cycle. Row-path and column-path commands that arrive in the same cycle are therefore merged without ambiguity. Errors come out as a registered pulse, with one cause bit for each kind of fault.

Top module: `row_state_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, every bank reads closed, every `bank_row` field reads zero, and `seq_err` and `err_cause` are zero.
- R2: An activate to a closed bank opens that bank. The row it carries appears in that bank's `bank_row` field (bank b occupies bits b*12 to b*12+11) one clock after the command.
- R3: An activate to an open bank sets `err_cause[0]`. It leaves that bank's stored row unchanged and does not open or close the bank.
- R4: A row-path precharge closes an open bank. A row-path precharge to a closed bank has no effect and raises no error, so an activate and a precharge to the same closed bank in the same cycle leave the bank open.
- R5: A column command to an open bank closes the bank when `col_autopre` is 1 and leaves it open when `col_autopre` is 0.
- R6: A column command to a closed bank sets `err_cause[1]` and is otherwise ignored. It changes no bank state and does not change the arm flag.
- R7: `col_kind` is encoded 00 = no-op, 01 = write, 10 = read, 11 = no-op. An accepted read, or an accepted write with `col_masked` = 0, arms the extended precharge. An accepted masked write or no-op disarms it. An extended precharge leaves the flag unchanged.
- R8: An extended precharge to an open bank while the arm flag is set closes that bank. The flag is taken as it stood before the cycle of the extended precharge.
- R9: An extended precharge while disarmed, or to a closed bank, sets `err_cause[2]` and changes no bank state.
- R10: `err_cause` and `seq_err` (the OR of the cause bits) reflect exactly the faults of the command cycle one clock earlier, so each fault gives a one-cycle pulse.
- R11: A bank's `bank_row` field keeps its last loaded row while the bank is closed and until the next accepted activate to that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_vld | input | 1 | Activate command valid |
| act_bank | input | 2 | Activate target bank |
| act_row | input | 12 | Row to latch |
| pre_vld | input | 1 | Row-path precharge valid |
| pre_bank | input | 2 | Row-path precharge target bank |
| col_vld | input | 1 | Column command valid |
| col_bank | input | 2 | Column command target bank |
| col_kind | input | 2 | Column operation: 00 no-op, 01 write, 10 read, 11 no-op |
| col_autopre | input | 1 | Close the bank at the end of the column operation |
| col_masked | input | 1 | Write uses byte masking |
| xpre_vld | input | 1 | Extended precharge valid |
| xpre_bank | input | 2 | Extended precharge target bank |
| bank_open | output | 4 | One open flag per bank |
| bank_row | output | 48 | Latched row per bank, 12 bits each |
| seq_err | output | 1 | Illegal-sequence pulse |
| err_cause | output | 3 | Bit0 activate on open bank, bit1 column on closed bank, bit2 refused extended precharge |

## Verification
The hardest situation to reach is an extended precharge whose outcome depends on column history that is not visible at the ports. The arm flag may have been set several commands earlier, by a column command whose own bank was auto-precharged. It may also be held across an ignored column command, or cleared by a reserved no-op code. The stimulus table therefore builds the arm state through explicit chains: read then extended precharge, masked write then a refused extended precharge, auto-precharged unmasked write then an extended precharge to a bank opened later. Row-path and column-path commands are also sent to the same bank in the same cycle, so that the start-of-cycle legality rule and the precedence of a close over a refused activate can both be observed.

// File: rtl/row_trk_pkg.sv
package row_trk_pkg;

  typedef enum logic [1:0] {
    CK_NOP_A = 2'b00,
    CK_WRITE = 2'b01,
    CK_READ  = 2'b10,
    CK_NOP_B = 2'b11
  } col_kind_e;

  localparam int ERR_W    = 3;
  localparam int ERR_ACT  = 0;
  localparam int ERR_COL  = 1;
  localparam int ERR_XPRE = 2;

  // A column command leaves the device armed for an extended precharge
  // only when it moved data without byte masking.
  function automatic logic arms_xpre(input col_kind_e kind, input logic masked);
    return (kind == CK_READ) || ((kind == CK_WRITE) && !masked);
  endfunction

endpackage

// File: rtl/trk_cmd_check.sv
module trk_cmd_check
  import row_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 act_vld,
  input  logic [BANK_W-1:0]    act_bank,
  input  logic                 pre_vld,
  input  logic [BANK_W-1:0]    pre_bank,
  input  logic                 col_vld,
  input  logic [BANK_W-1:0]    col_bank,
  input  logic [1:0]           col_kind,
  input  logic                 col_autopre,
  input  logic                 col_masked,
  input  logic                 xpre_vld,
  input  logic [BANK_W-1:0]    xpre_bank,
  input  logic [NUM_BANKS-1:0] open_q,
  input  logic                 armed_q,
  output logic [NUM_BANKS-1:0] open_set,
  output logic [NUM_BANKS-1:0] close_set,
  output logic                 arm_upd,
  output logic                 arm_val,
  output logic [ERR_W-1:0]     err_now
);

  function automatic logic [NUM_BANKS-1:0] dec(input logic [BANK_W-1:0] b);
    logic [NUM_BANKS-1:0] v;
    v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  logic act_ok, col_ok, xpre_ok;

  // Legality is judged on the state held at the start of the cycle.
  always_comb begin
    act_ok  = act_vld  && !open_q[act_bank];
    col_ok  = col_vld  &&  open_q[col_bank];
    xpre_ok = xpre_vld &&  armed_q && open_q[xpre_bank];

    open_set  = act_ok ? dec(act_bank) : '0;
    close_set = (pre_vld ? dec(pre_bank) : '0)
              | ((col_ok && col_autopre) ? dec(col_bank) : '0)
              | (xpre_ok ? dec(xpre_bank) : '0);

    arm_upd = col_ok;
    arm_val = arms_xpre(col_kind_e'(col_kind), col_masked);

    err_now           = '0;
    err_now[ERR_ACT]  = act_vld && !act_ok;
    err_now[ERR_COL]  = col_vld && !col_ok;
    err_now[ERR_XPRE] = xpre_vld && !xpre_ok;
  end

endmodule

// File: rtl/trk_bank_slot.sv
module trk_bank_slot #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             close_set,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q
);

  logic load;
  assign load = open_set && !open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      if (open_q) open_q <= !close_set;
      else        open_q <= open_set;
      if (load) row_q <= row_in;
    end
  end

  a_r2_open_loads_row: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (open_q && row_q == $past(row_in)));

  a_r3_row_kept_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> row_q == $past(row_q));

  a_r4_close_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && close_set) |=> !open_q);

  a_r11_row_kept_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !open_set |=> row_q == $past(row_q));

endmodule

// File: rtl/trk_xpre_arm.sv
module trk_xpre_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic val,
  output logic armed_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (upd) armed_q <= val;
  end

  a_r7_arm_changes_only_on_column: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> armed_q == $past(armed_q));

endmodule

// File: rtl/row_state_tracker.sv
module row_state_tracker
  import row_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int ROW_W     = 12,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_vld,
  input  logic [BANK_W-1:0]          act_bank,
  input  logic [ROW_W-1:0]           act_row,
  input  logic                       pre_vld,
  input  logic [BANK_W-1:0]          pre_bank,
  input  logic                       col_vld,
  input  logic [BANK_W-1:0]          col_bank,
  input  logic [1:0]                 col_kind,
  input  logic                       col_autopre,
  input  logic                       col_masked,
  input  logic                       xpre_vld,
  input  logic [BANK_W-1:0]          xpre_bank,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic                       seq_err,
  output logic [ERR_W-1:0]           err_cause
);

  logic [NUM_BANKS-1:0] open_set, close_set;
  logic                 arm_upd, arm_val, armed_q;
  logic [ERR_W-1:0]     err_now, err_q;

  trk_cmd_check #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_check (
    .act_vld     (act_vld),
    .act_bank    (act_bank),
    .pre_vld     (pre_vld),
    .pre_bank    (pre_bank),
    .col_vld     (col_vld),
    .col_bank    (col_bank),
    .col_kind    (col_kind),
    .col_autopre (col_autopre),
    .col_masked  (col_masked),
    .xpre_vld    (xpre_vld),
    .xpre_bank   (xpre_bank),
    .open_q      (bank_open),
    .armed_q     (armed_q),
    .open_set    (open_set),
    .close_set   (close_set),
    .arm_upd     (arm_upd),
    .arm_val     (arm_val),
    .err_now     (err_now)
  );

  trk_xpre_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (arm_upd),
    .val     (arm_val),
    .armed_q (armed_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    trk_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_set  (open_set[b]),
      .close_set (close_set[b]),
      .row_in    (act_row),
      .open_q    (bank_open[b]),
      .row_q     (bank_row[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_now;
  end

  assign err_cause = err_q;
  assign seq_err   = |err_q;

  a_r3_act_on_open_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && bank_open[act_bank]) |=> err_cause[ERR_ACT]);

  a_r6_col_on_closed_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !bank_open[col_bank] && !act_vld && !pre_vld && !xpre_vld)
      |=> (bank_open == $past(bank_open) && err_cause[ERR_COL]));

  a_r8_xpre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (xpre_vld && armed_q && bank_open[xpre_bank]) |=> !bank_open[$past(xpre_bank)]);

  a_r9_xpre_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (xpre_vld && !armed_q) |=> err_cause[ERR_XPRE]);

  a_r10_quiet_cycle_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_vld && !col_vld && !xpre_vld) |=> !seq_err);

endmodule

// File: tb/row_state_tracker_tb.sv
module row_state_tracker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_vld = 1'b0, pre_vld = 1'b0, col_vld = 1'b0, xpre_vld = 1'b0;
  logic [1:0]  act_bank = '0, pre_bank = '0, col_bank = '0, xpre_bank = '0, col_kind = '0;
  logic [11:0] act_row = '0;
  logic        col_autopre = 1'b0, col_masked = 1'b0;
  logic [3:0]  bank_open;
  logic [47:0] bank_row;
  logic        seq_err;
  logic [2:0]  err_cause;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  row_state_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .act_vld(act_vld), .act_bank(act_bank), .act_row(act_row),
    .pre_vld(pre_vld), .pre_bank(pre_bank),
    .col_vld(col_vld), .col_bank(col_bank), .col_kind(col_kind),
    .col_autopre(col_autopre), .col_masked(col_masked),
    .xpre_vld(xpre_vld), .xpre_bank(xpre_bank),
    .bank_open(bank_open), .bank_row(bank_row),
    .seq_err(seq_err), .err_cause(err_cause)
  );

  typedef struct packed {
    logic        av; logic [1:0] ab; logic [11:0] ar;
    logic        pv; logic [1:0] pb;
    logic        cv; logic [1:0] cb; logic [1:0] ck; logic cap; logic cm;
    logic        xv; logic [1:0] xb;
    logic [3:0]  eo; logic [2:0] ee;
    logic [1:0]  rb; logic [11:0] er;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1,2'd0,12'h123, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0001,3'b000, 2'd0,12'h123},
    '{1'b1,2'd1,12'hFFF, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0011,3'b000, 2'd1,12'hFFF},
    '{1'b1,2'd0,12'h555, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0011,3'b001, 2'd0,12'h123},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b1,2'd2,2'b10,1'b0,1'b0, 1'b0,2'd0, 4'b0011,3'b010, 2'd2,12'h000},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b1,2'd0,2'b10,1'b0,1'b0, 1'b0,2'd0, 4'b0011,3'b000, 2'd0,12'h123},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b1,2'd0, 4'b0010,3'b000, 2'd0,12'h123},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b1,2'd1,2'b01,1'b0,1'b1, 1'b0,2'd0, 4'b0010,3'b000, 2'd1,12'hFFF},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b1,2'd1, 4'b0010,3'b100, 2'd1,12'hFFF},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b1,2'd1,2'b01,1'b0,1'b0, 1'b0,2'd0, 4'b0010,3'b000, 2'd1,12'hFFF},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b1,2'd3, 4'b0010,3'b100, 2'd3,12'h000},
    '{1'b0,2'd0,12'h000, 1'b1,2'd1, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0000,3'b000, 2'd1,12'hFFF},
    '{1'b0,2'd0,12'h000, 1'b1,2'd1, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0000,3'b000, 2'd1,12'hFFF},
    '{1'b1,2'd2,12'h001, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0100,3'b000, 2'd2,12'h001},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b1,2'd2,2'b00,1'b1,1'b0, 1'b0,2'd0, 4'b0000,3'b000, 2'd2,12'h001},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b1,2'd2, 4'b0000,3'b100, 2'd2,12'h001},
    '{1'b1,2'd3,12'hABC, 1'b0,2'd0, 1'b1,2'd3,2'b10,1'b1,1'b0, 1'b0,2'd0, 4'b1000,3'b010, 2'd3,12'hABC},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b1,2'd3,2'b01,1'b1,1'b0, 1'b0,2'd0, 4'b0000,3'b000, 2'd3,12'hABC},
    '{1'b1,2'd0,12'h0AA, 1'b1,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0001,3'b000, 2'd0,12'h0AA},
    '{1'b1,2'd0,12'h0BB, 1'b1,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0000,3'b001, 2'd0,12'h0AA},
    '{1'b1,2'd1,12'h010, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0010,3'b000, 2'd1,12'h010},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b1,2'd1, 4'b0000,3'b000, 2'd1,12'h010},
    '{1'b1,2'd1,12'h020, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b0,2'd0, 4'b0010,3'b000, 2'd1,12'h020},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b1,2'd1,2'b11,1'b0,1'b0, 1'b0,2'd0, 4'b0010,3'b000, 2'd1,12'h020},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0, 1'b0,2'd0,2'b00,1'b0,1'b0, 1'b1,2'd1, 4'b0010,3'b100, 2'd1,12'h020}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    act_vld = 1'b0; pre_vld = 1'b0; col_vld = 1'b0; xpre_vld = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    act_vld = v.av; act_bank = v.ab; act_row = v.ar;
    pre_vld = v.pv; pre_bank = v.pb;
    col_vld = v.cv; col_bank = v.cb; col_kind = v.ck;
    col_autopre = v.cap; col_masked = v.cm;
    xpre_vld = v.xv; xpre_bank = v.xb;
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " R1 bank_open"}, 64'(bank_open), 64'h0);
    chk({tag, " R1 bank_row"}, 64'(bank_row), 64'h0);
    chk({tag, " R1 seq_err"}, 64'(seq_err), 64'h0);
    chk({tag, " R1 err_cause"}, 64'(err_cause), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("after reset");

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      idle();
      chk($sformatf("vec%0d R2 R4 R5 R8 bank_open", i), 64'(bank_open), 64'(VEC[i].eo));
      chk($sformatf("vec%0d R3 R6 R7 R9 R10 err_cause", i), 64'(err_cause), 64'(VEC[i].ee));
      chk($sformatf("vec%0d R10 seq_err", i), 64'(seq_err), 64'(|VEC[i].ee));
      chk($sformatf("vec%0d R2 R3 R11 bank_row", i),
          64'(bank_row[VEC[i].rb*12 +: 12]), 64'(VEC[i].er));
    end

    // R10: one pulse per fault, gone after a quiet cycle.
    act_vld = 1'b1; act_bank = 2'd1; act_row = 12'h777;
    @(negedge clk);
    idle();
    chk("R10 pulse high", 64'({seq_err, err_cause}), 64'h9);
    chk("R3 row kept on refused activate", 64'(bank_row[12 +: 12]), 64'h020);
    @(negedge clk);
    chk("R10 pulse ends", 64'({seq_err, err_cause}), 64'h0);
    chk("R11 rows held over idle", 64'(bank_row), {16'h0, 12'hABC, 12'h001, 12'h020, 12'h0AA});

    // R1: reset in the middle of activity clears everything.
    act_vld = 1'b1; act_bank = 2'd3; act_row = 12'h3C3;
    rst_n = 1'b0;
    @(negedge clk);
    idle();
    chk_reset_state("mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("released");

    // R7: arm flag cleared by reset, so an extended precharge is refused.
    act_vld = 1'b1; act_bank = 2'd2; act_row = 12'h042;
    @(negedge clk);
    idle();
    xpre_vld = 1'b1; xpre_bank = 2'd2;
    @(negedge clk);
    idle();
    chk("R9 R7 refused after reset", 64'({bank_open, err_cause}), {57'h0, 4'b0100, 3'b100});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule